// File: doc/BRIEF.md
# Carry-Increment Group Adder

A combinational N-bit binary adder that splits its operands into equal groups of a parameterized size. Bitwise generate (a AND b) and propagate (a XOR b) terms are formed once for all bits. Inside each group, a short ripple prefix computes every partial carry on the assumption that the group's carry-in is zero. It also keeps a running AND of the propagate terms.

When the true carry-in of a group is known, one AND-OR per bit corrects the assumed carries. This is the increment step, and it yields the same result as choosing between a carry-in-0 sum and a carry-in-1 sum. The corrected carry out of a group's top bit feeds the next group through the same AND-OR, so the chain between groups costs one gate level per group. A single XOR stage shared by all bits forms the sum from the propagate terms and the corrected carries.

The block is used wherever a medium-width add must be faster than a plain ripple adder without the area of a tree adder. The group width must divide the operand width; any other value is rejected at elaboration.

Top module: `cia_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of the unsigned sum `a + b + cin`, for every operand pair and carry-in.
- R2: `cout` equals bit WIDTH of the unsigned sum `a + b + cin`, so that `{cout, sum}` is the full (WIDTH+1)-bit result.
- R3: When every bit position propagates (`a ^ b` all ones), `cout` equals `cin` and every bit of `sum` equals the inverse of `cin`.
- R4: The carry entering each group, at bit position k*GRP, equals bit k*GRP of `(a mod 2^(k*GRP)) + (b mod 2^(k*GRP)) + cin`. The carry leaving the top group is `cout`.
- R5: With `b` zero and `cin` zero, `sum` equals `a` and `cout` is 0. With `b` zero and `cin` one, the result is `a + 1`.
- R6: When both operands have their most significant bit set, `cout` is 1 whatever the lower bits and `cin` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds two copies of the adder. A narrow one, 8 bits wide with 2-bit groups, has four groups and three inter-group increment links. It is small enough that every operand pair is tried with both carry-in values, so every combination of group generate and propagate is reached. A wide one, 32 bits with 4-bit groups, is driven with random operands and with directed patterns. These patterns include full propagate runs that cross all eight groups, carries that start exactly at a group boundary, and sign-bit generate. They show that the chain behaves the same at the intended size.

// File: rtl/cia_pkg.sv
// Package: shared helpers for the carry-increment adder.
// Holds the AND-OR carry operator used by both the in-group
// prefix and the carry-in correction stage.
package cia_pkg;

    // Carry out of a span given its generate, propagate and incoming carry.
    function automatic logic cia_ao(input logic gen, input logic prop, input logic cin);
        return gen | (prop & cin);
    endfunction

endpackage

// File: rtl/cia_pg_bits.sv
// Module: cia_pg_bits
// Forms the per-bit generate (a AND b) and propagate (a XOR b).
// Assumes nothing beyond equal operand widths; purely combinational.
module cia_pg_bits #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] g_o,
    output logic [W-1:0] p_o
);

    // Bitwise generate and propagate terms.
    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i ^ b_i;
    end

endmodule

// File: rtl/cia_group_prefix.sv
// Module: cia_group_prefix
// Within one group, computes for each bit i the carry out of bits
// [i:0] assuming a zero group carry-in (gg_o), and the AND of the
// propagate terms over [i:0] (pp_o). Ripples inside the group.
// Assumes GW >= 1.
module cia_group_prefix
    import cia_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] g_i,
    input  logic [GW-1:0] p_i,
    output logic [GW-1:0] gg_o,
    output logic [GW-1:0] pp_o
);

    // Lowest bit of the group: spans are just the bit itself.
    assign gg_o[0] = g_i[0];
    assign pp_o[0] = p_i[0];

    // Extend each span by one bit using the AND-OR operator.
    for (genvar i = 1; i < GW; i++) begin : g_span
        assign gg_o[i] = cia_ao(g_i[i], p_i[i], gg_o[i-1]);
        assign pp_o[i] = p_i[i] & pp_o[i-1];
    end

endmodule

// File: rtl/cia_increment.sv
// Module: cia_increment
// Corrects the carry-in-0 group carries once the real group
// carry-in is known: c_o[i] = gg_i[i] | (pp_i[i] & cin_i).
// c_o[GW-1] is the group carry-out. Assumes GW >= 1.
module cia_increment
    import cia_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic          cin_i,
    input  logic [GW-1:0] gg_i,
    input  logic [GW-1:0] pp_i,
    output logic [GW-1:0] c_o
);

    // One AND-OR per bit; all share the same group carry-in.
    for (genvar i = 0; i < GW; i++) begin : g_fix
        assign c_o[i] = cia_ao(gg_i[i], pp_i[i], cin_i);
    end

endmodule

// File: rtl/cia_sum_xor.sv
// Module: cia_sum_xor
// Final sum stage shared by all groups: sum bit = propagate XOR
// the carry entering that bit.
module cia_sum_xor #(
    parameter int W = 32
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o
);

    // Single XOR per bit.
    assign s_o = p_i ^ c_i;

endmodule

// File: rtl/cia_adder.sv
// Module: cia_adder (top)
// Combinational WIDTH-bit adder built from GRP-bit groups. Each group
// computes carries assuming carry-in 0, then an increment step fixes
// them with the real group carry-in. PG generation and the sum XOR
// are shared. Assumes WIDTH is a positive multiple of GRP.
module cia_adder #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NGRP = WIDTH / GRP;

    // Elaboration guard: group size must tile the word exactly.
    if (GRP < 1 || NGRP * GRP != WIDTH) begin : g_bad_grp
        $error("cia_adder: WIDTH must be a positive multiple of GRP");
    end

    logic [WIDTH-1:0] g_bit;
    logic [WIDTH-1:0] p_bit;
    logic [WIDTH-1:0] c_bit;    // carry entering each bit
    logic [NGRP:0]    grp_cin;  // carry entering each group; top = cout

    // Shared bitwise PG stage.
    cia_pg_bits #(.W(WIDTH)) u_pg (
        .a_i (a),
        .b_i (b),
        .g_o (g_bit),
        .p_o (p_bit)
    );

    assign grp_cin[0] = cin;

    // One prefix and one increment stage per group, chained by carry.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic [GRP-1:0] gg;
        logic [GRP-1:0] pp;
        logic [GRP-1:0] cc;

        cia_group_prefix #(.GW(GRP)) u_pre (
            .g_i  (g_bit[k*GRP +: GRP]),
            .p_i  (p_bit[k*GRP +: GRP]),
            .gg_o (gg),
            .pp_o (pp)
        );

        cia_increment #(.GW(GRP)) u_inc (
            .cin_i (grp_cin[k]),
            .gg_i  (gg),
            .pp_i  (pp),
            .c_o   (cc)
        );

        assign c_bit[k*GRP] = grp_cin[k];
        if (GRP > 1) begin : g_upper
            assign c_bit[k*GRP+1 +: GRP-1] = cc[GRP-2:0];
        end
        assign grp_cin[k+1] = cc[GRP-1];
    end

    // Shared final XOR stage.
    cia_sum_xor #(.W(WIDTH)) u_sum (
        .p_i (p_bit),
        .c_i (c_bit),
        .s_o (sum)
    );

    assign cout = grp_cin[NGRP];

endmodule

// File: rtl/cia_adder_chk.sv
// Module: cia_adder_chk
// Assertion checker bound to cia_adder. The block has no clock, so the
// checks are immediate assertions evaluated whenever the inputs settle.
module cia_adder_chk #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input logic [WIDTH-1:0]      a,
    input logic [WIDTH-1:0]      b,
    input logic                  cin,
    input logic [WIDTH-1:0]      sum,
    input logic                  cout,
    input logic [WIDTH/GRP:0]    grp_cin
);

    localparam int NGRP = WIDTH / GRP;

    // Arithmetic and group-carry properties against a wide reference add.
    always_comb begin
        logic [WIDTH:0] full;
        full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        a_r1_sum_value: assert (sum == full[WIDTH-1:0])
            else $error("R1 sum mismatch");
        a_r2_carry_out: assert (cout == full[WIDTH])
            else $error("R2 cout mismatch");
        if ((a ^ b) == {WIDTH{1'b1}}) begin
            a_r3_full_propagate: assert (cout == cin && sum == {WIDTH{~cin}})
                else $error("R3 propagate run mismatch");
        end
        if (b == '0) begin
            a_r5_zero_addend: assert ({cout, sum} == {1'b0, a} + {{WIDTH{1'b0}}, cin})
                else $error("R5 zero addend mismatch");
        end
        if (a[WIDTH-1] && b[WIDTH-1]) begin
            a_r6_top_generate: assert (cout)
                else $error("R6 top generate lost");
        end
        for (int k = 1; k <= NGRP; k++) begin
            logic [WIDTH:0] mask;
            logic [WIDTH:0] part;
            mask = ({{WIDTH{1'b0}}, 1'b1} << (k*GRP)) - 1'b1;
            part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, cin};
            a_r4_group_carry: assert (grp_cin[k] == part[k*GRP])
                else $error("R4 group carry mismatch");
        end
    end

endmodule

bind cia_adder cia_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .grp_cin (grp_cin)
);

// File: tb/tb_cia_adder.sv
// Bench for cia_adder: a 32-bit/4-bit-group copy driven by directed and
// random patterns, and an 8-bit/2-bit-group copy checked exhaustively.
module tb_cia_adder;

    localparam int W  = 32;
    localparam int G  = 4;
    localparam int WS = 8;
    localparam int GS = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [W-1:0]  a_w, b_w, s_w;
    logic          ci_w, co_w;
    logic [WS-1:0] a_s, b_s, s_s;
    logic          ci_s, co_s;

    cia_adder #(.WIDTH(W), .GRP(G)) dut (
        .a(a_w), .b(b_w), .cin(ci_w), .sum(s_w), .cout(co_w)
    );

    cia_adder #(.WIDTH(WS), .GRP(GS)) dut_small (
        .a(a_s), .b(b_s), .cin(ci_s), .sum(s_s), .cout(co_s)
    );

    // Apply one wide vector and compare against an independent add.
    task automatic chk_wide(input logic [W-1:0] x, input logic [W-1:0] y,
                            input logic c, input string req);
        logic [W:0] exp;
        a_w = x; b_w = y; ci_w = c;
        #1;
        exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        checks++;
        if ({co_w, s_w} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     req, x, y, c, {co_w, s_w}, exp);
        end
    endtask

    // Apply one narrow vector and compare against an independent add.
    task automatic chk_small(input logic [WS-1:0] x, input logic [WS-1:0] y,
                             input logic c, input string req);
        logic [WS:0] exp;
        a_s = x; b_s = y; ci_s = c;
        #1;
        exp = {1'b0, x} + {1'b0, y} + {{WS{1'b0}}, c};
        checks++;
        if ({co_s, s_s} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     req, x, y, c, {co_s, s_s}, exp);
        end
    endtask

    // Scenario: all-zero inputs give an all-zero result (R1, R2).
    task automatic t_idle();
        chk_wide('0, '0, 1'b0, "R1 R2 zero inputs");
        chk_small('0, '0, 1'b0, "R1 R2 zero inputs small");
    endtask

    // Scenario: every operand pair and carry-in on the narrow copy (R1, R2, R4).
    task automatic t_exhaustive_small();
        for (int x = 0; x < (1 << WS); x++)
            for (int y = 0; y < (1 << WS); y++)
                for (int c = 0; c < 2; c++)
                    chk_small(WS'(x), WS'(y), c[0], "R1 R2 R4 exhaustive");
    endtask

    // Scenario: random wide operands (R1, R2).
    task automatic t_random_wide();
        for (int i = 0; i < 3000; i++)
            chk_wide($urandom, $urandom, 1'($urandom), "R1 R2 random");
    endtask

    // Scenario: full propagate run crossing every group (R3).
    task automatic t_full_propagate();
        logic [W-1:0] x;
        for (int c = 0; c < 2; c++) begin
            x = 32'h5A5A_F00F;
            a_w = x; b_w = ~x; ci_w = c[0];
            #1;
            checks++;
            if (co_w !== c[0] || s_w !== {W{~c[0]}}) begin
                failures++;
                $display("FAIL R3 cin=%0d actual=%b_%h expected=%b_%h",
                         c, co_w, s_w, c[0], {W{~c[0]}});
            end
        end
        chk_wide('1, '0, 1'b1, "R3 all ones plus carry");
    endtask

    // Scenario: carries that begin at and cross each group boundary (R4).
    task automatic t_group_edges();
        for (int k = 1; k <= W / G; k++) begin
            logic [W-1:0] low;
            low = (k == W / G) ? '1 : ((W'(1) << (k*G)) - 1'b1);
            chk_wide(low, W'(1), 1'b0, "R4 boundary carry");
            chk_wide(low, '0, 1'b1, "R4 boundary carry via cin");
            chk_wide(W'(1) << (k*G - 1), W'(1) << (k*G - 1), 1'b0, "R4 generate at group top");
        end
    endtask

    // Scenario: zero second addend passes the first through (R5).
    task automatic t_zero_addend();
        chk_wide(32'hDEAD_BEEF, '0, 1'b0, "R5 pass-through");
        chk_wide(32'h0000_FFFF, '0, 1'b1, "R5 increment");
        chk_wide('1, '0, 1'b0, "R5 all ones pass-through");
    endtask

    // Scenario: both sign bits set force a carry-out (R6).
    task automatic t_top_generate();
        logic [W-1:0] hi;
        hi = W'(1) << (W - 1);
        for (int c = 0; c < 2; c++) begin
            a_w = hi; b_w = hi; ci_w = c[0];
            #1;
            checks++;
            if (co_w !== 1'b1) begin
                failures++;
                $display("FAIL R6 cin=%0d actual=%b expected=1", c, co_w);
            end
        end
        chk_wide(hi | 32'h0000_1234, hi | 32'h0F00_0001, 1'b1, "R6 top generate mixed");
    endtask

    // Main sequence: runs each scenario, then prints the summary.
    initial begin
        a_w = '0; b_w = '0; ci_w = 1'b0;
        a_s = '0; b_s = '0; ci_s = 1'b0;
        @(negedge clk);
        t_idle();
        t_full_propagate();
        t_group_edges();
        t_zero_addend();
        t_top_generate();
        t_random_wide();
        t_exhaustive_small();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule